// File: doc/BRIEF.md
# Program Counter and Control Register Unit

This unit holds the architectural program counter, a one-bit instruction-set mode flag, a 32-bit status register and an indexed bank of 64-bit control registers. An execution pipeline writes the PC through a dedicated port. Every PC write splits its value in two. The least significant bit selects the instruction-set mode, and the PC keeps the rest of the value with bit 0 cleared. The mode flag has no write path of its own.

Control register index 0 has no storage of its own. It is a window onto the status register: a read returns the status register zero-extended, and a write loads the status register. The other indices are plain 64-bit storage. A second port reads or updates a single named status flag through a 3-bit selector, so the pipeline can change one flag without a read-modify-write. Reads of both ports are combinational. Writes land on the next rising clock edge.

Top module: `cru_top`

## Requirements
- R1: A PC write (`pc_we_i`) makes `pc_o` equal to `pc_wdata_i` with bit 0 cleared after the next rising edge.
- R2: A PC write makes `mode_o` equal to bit 0 of `pc_wdata_i` after the next rising edge.
- R3: `mode_o` changes only through a PC write. Control register writes and flag writes leave it unchanged.
- R4: With `cr_idx_i` equal to 0, `cr_rdata_o` returns the status register in bits 31:0 and zeros in bits 63:32. `sr_o` always shows the status register.
- R5: A control register write to index 0 loads the status register with bits 31:0 of `cr_wdata_i` and discards the upper half. It changes no other control register.
- R6: A write to index 1 through 63 stores all 64 bits in that entry only. A later combinational read at that index returns the stored value.
- R7: `flag_sel_i` codes select the following status bits: 0 is bit 14 (FP bank select), 1 is bit 13 (FP transfer size), 2 is bit 12 (FP precision), 3 is bit 9 (divide M), 4 is bit 8 (divide Q), 5 is bit 1 (MAC saturation). `flag_rdata_o` shows the selected bit combinationally. Codes 6 and 7 read 0, and writes with these codes leave the status register unchanged.
- R8: A flag write (`flag_we_i`) with a valid code sets the selected bit to `flag_wdata_i` and preserves every other status bit.
- R9: When a flag write and a control register 0 write occur in the same cycle, the status register takes the control register value and the flag write is dropped.
- R10: After reset the PC, mode flag, status register and every control register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pc_we_i | input | 1 | PC write enable |
| pc_wdata_i | input | 64 | PC write value, bit 0 is the mode |
| pc_o | output | 64 | Current PC |
| mode_o | output | 1 | Instruction-set mode flag |
| cr_idx_i | input | 6 | Control register index |
| cr_we_i | input | 1 | Control register write enable |
| cr_wdata_i | input | 64 | Control register write data |
| cr_rdata_o | output | 64 | Control register read data |
| flag_sel_i | input | 3 | Status flag selector |
| flag_we_i | input | 1 | Status flag write enable |
| flag_wdata_i | input | 1 | Status flag write value |
| flag_rdata_o | output | 1 | Selected status flag |
| sr_o | output | 32 | Status register |

## Verification
The bench uses the default parameters: 64-bit registers and 64 control registers. Random indices therefore reach the top entry, 63, and the aliased index 0. Index 0 is drawn on a quarter of the writes, so PC writes, alias writes and flag writes collide often. Random flag codes include the two unused selector values. Directed cases cover odd PC values, the discarded upper half of an alias write and the collision priority.

// File: rtl/cru_pkg.sv
package cru_pkg;
  localparam int SR_W = 32;

  typedef enum logic [2:0] {
    FLAG_FP_BANK  = 3'd0,
    FLAG_FP_SIZE  = 3'd1,
    FLAG_FP_PREC  = 3'd2,
    FLAG_DIV_M    = 3'd3,
    FLAG_DIV_Q    = 3'd4,
    FLAG_MAC_SAT  = 3'd5
  } flag_sel_e;

  function automatic logic flag_valid(logic [2:0] sel);
    return sel <= 3'd5;
  endfunction

  function automatic logic [4:0] flag_pos(logic [2:0] sel);
    case (sel)
      FLAG_FP_BANK: return 5'd14;
      FLAG_FP_SIZE: return 5'd13;
      FLAG_FP_PREC: return 5'd12;
      FLAG_DIV_M:   return 5'd9;
      FLAG_DIV_Q:   return 5'd8;
      FLAG_MAC_SAT: return 5'd1;
      default:      return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/cru_pc.sv
module cru_pc #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic            mode_o
);
  logic [XLEN-1:0] pc_q;
  logic            mode_q;

  // mode flag has no write path except through the PC
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      mode_q <= 1'b0;
    end else if (we_i) begin
      pc_q   <= {wdata_i[XLEN-1:1], 1'b0};
      mode_q <= wdata_i[0];
    end
  end

  assign pc_o   = pc_q;
  assign mode_o = mode_q;

  p_pc_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (pc_o[XLEN-1:1] == $past(wdata_i[XLEN-1:1])) && !pc_o[0]);
  p_mode_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mode_o == $past(wdata_i[0]));
  p_mode_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mode_o));
endmodule

// File: rtl/cru_status.sv
module cru_status
  import cru_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cr0_we_i,
  input  logic [SR_W-1:0] cr0_wdata_i,
  input  logic            flag_we_i,
  input  logic [2:0]      flag_sel_i,
  input  logic            flag_wdata_i,
  output logic            flag_rdata_o,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] flag_mask;
  logic            sel_ok;

  assign sel_ok    = flag_valid(flag_sel_i);
  assign flag_mask = sel_ok ? (SR_W'(1) << flag_pos(flag_sel_i)) : '0;

  // full-register alias write wins over a single-flag write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sr_q <= '0;
    else if (cr0_we_i)            sr_q <= cr0_wdata_i;
    else if (flag_we_i && sel_ok) sr_q <= (sr_q & ~flag_mask) | (flag_wdata_i ? flag_mask : '0);
  end

  assign flag_rdata_o = |(sr_q & flag_mask);
  assign sr_o         = sr_q;

  p_flag_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !cr0_we_i) |=> ((sr_q ^ $past(sr_q)) & ~$past(flag_mask)) == '0);
  p_cr0_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr0_we_i |=> sr_q == $past(cr0_wdata_i));
  p_bad_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && !sel_ok && !cr0_we_i) |=> $stable(sr_q));
endmodule

// File: rtl/cru_bank.sv
module cru_bank #(
  parameter int XLEN   = 64,
  parameter int NUM_CR = 64,
  localparam int IDX_W = $clog2(NUM_CR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o
);
  // entry 0 is aliased elsewhere, so storage starts at 1
  logic [XLEN-1:0] regs_q [1:NUM_CR-1];

  for (genvar g = 1; g < NUM_CR; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))  regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 1; i < NUM_CR; i++)
      if (idx_i == IDX_W'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/cru_top.sv
module cru_top
  import cru_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NUM_CR = 64,
  localparam int IDX_W = $clog2(NUM_CR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pc_we_i,
  input  logic [XLEN-1:0]  pc_wdata_i,
  output logic [XLEN-1:0]  pc_o,
  output logic             mode_o,
  input  logic [IDX_W-1:0] cr_idx_i,
  input  logic             cr_we_i,
  input  logic [XLEN-1:0]  cr_wdata_i,
  output logic [XLEN-1:0]  cr_rdata_o,
  input  logic [2:0]       flag_sel_i,
  input  logic             flag_we_i,
  input  logic             flag_wdata_i,
  output logic             flag_rdata_o,
  output logic [SR_W-1:0]  sr_o
);
  logic            idx_zero;
  logic [XLEN-1:0] bank_rdata;
  logic [SR_W-1:0] sr;

  assign idx_zero = (cr_idx_i == '0);

  cru_pc #(.XLEN(XLEN)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pc_we_i),
    .wdata_i(pc_wdata_i),
    .pc_o   (pc_o),
    .mode_o (mode_o)
  );

  cru_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cr0_we_i    (cr_we_i && idx_zero),
    .cr0_wdata_i (cr_wdata_i[SR_W-1:0]),
    .flag_we_i   (flag_we_i),
    .flag_sel_i  (flag_sel_i),
    .flag_wdata_i(flag_wdata_i),
    .flag_rdata_o(flag_rdata_o),
    .sr_o        (sr)
  );

  cru_bank #(.XLEN(XLEN), .NUM_CR(NUM_CR)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cr_we_i && !idx_zero),
    .idx_i  (cr_idx_i),
    .wdata_i(cr_wdata_i),
    .rdata_o(bank_rdata)
  );

  assign sr_o       = sr;
  assign cr_rdata_o = idx_zero ? {{(XLEN-SR_W){1'b0}}, sr} : bank_rdata;

  p_cr0_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_zero |-> (cr_rdata_o[XLEN-1:SR_W] == '0) && (cr_rdata_o[SR_W-1:0] == sr_o));
  p_bank_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && !idx_zero) |=>
      (cr_idx_i != $past(cr_idx_i)) || (cr_rdata_o == $past(cr_wdata_i)));
  p_cr0_only_sr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_we_i && idx_zero && !pc_we_i) |=> $stable(pc_o) && $stable(mode_o));
endmodule

// File: tb/tb_cru_top.sv
`timescale 1ns/1ps
module tb_cru_top;
  localparam int XLEN = 64;
  localparam int NCR  = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pc_we = 1'b0;
  logic [XLEN-1:0] pc_wdata = '0;
  logic [XLEN-1:0] pc;
  logic            mode;
  logic [5:0]      cr_idx = '0;
  logic            cr_we = 1'b0;
  logic [XLEN-1:0] cr_wdata = '0;
  logic [XLEN-1:0] cr_rdata;
  logic [2:0]      flag_sel = '0;
  logic            flag_we = 1'b0;
  logic            flag_wdata = 1'b0;
  logic            flag_rdata;
  logic [31:0]     sr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [XLEN-1:0] m_pc;
  logic            m_mode;
  logic [31:0]     m_sr;
  logic [XLEN-1:0] m_cr [NCR];

  always #2 clk = ~clk;

  cru_top dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pc_we_i(pc_we), .pc_wdata_i(pc_wdata), .pc_o(pc), .mode_o(mode),
    .cr_idx_i(cr_idx), .cr_we_i(cr_we), .cr_wdata_i(cr_wdata), .cr_rdata_o(cr_rdata),
    .flag_sel_i(flag_sel), .flag_we_i(flag_we), .flag_wdata_i(flag_wdata),
    .flag_rdata_o(flag_rdata), .sr_o(sr)
  );

  function automatic int exp_pos(logic [2:0] s);
    case (s)
      3'd0: return 14;
      3'd1: return 13;
      3'd2: return 12;
      3'd3: return 9;
      3'd4: return 8;
      3'd5: return 1;
      default: return -1;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] exp_read(logic [5:0] idx);
    if (idx == 0) return {32'd0, m_sr};
    return m_cr[idx];
  endfunction

  function automatic logic exp_flag(logic [2:0] s);
    int p = exp_pos(s);
    if (p < 0) return 1'b0;
    return m_sr[p];
  endfunction

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_mode = 0; m_sr = '0;
    for (int i = 0; i < NCR; i++) m_cr[i] = '0;
  endtask

  // drive at negedge, check combinational reads, clock, update model, check state
  task automatic cycle(bit pw, logic [XLEN-1:0] pd, bit cw, logic [5:0] ci,
                       logic [XLEN-1:0] cd, bit fw, logic [2:0] fs, bit fv);
    int p;
    @(negedge clk);
    pc_we = pw; pc_wdata = pd; cr_we = cw; cr_idx = ci; cr_wdata = cd;
    flag_we = fw; flag_sel = fs; flag_wdata = fv;
    #1;
    chk(ci == 0 ? "R4 cr read" : "R6 cr read", cr_rdata, exp_read(ci));
    chk("R7 flag read", {63'd0, flag_rdata}, {63'd0, exp_flag(fs)});
    @(posedge clk);
    if (pw) begin m_pc = {pd[XLEN-1:1], 1'b0}; m_mode = pd[0]; end
    if (cw) begin
      if (ci == 0) m_sr = cd[31:0];
      else         m_cr[ci] = cd;
    end
    p = exp_pos(fs);
    if (fw && p >= 0 && !(cw && ci == 0)) m_sr[p] = fv;
    @(negedge clk);
    pc_we = 0; cr_we = 0; flag_we = 0;
    chk("R1 pc", pc, m_pc);
    chk(pw ? "R2 mode" : "R3 mode", {63'd0, mode}, {63'd0, m_mode});
    chk((cw && ci == 0) ? (fw ? "R9 sr" : "R5 sr") : "R8 sr", {32'd0, sr}, {32'd0, m_sr});
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    model_reset();
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 pc", pc, '0);
    chk("R10 mode", {63'd0, mode}, '0);
    chk("R10 sr", {32'd0, sr}, '0);
    cr_idx = 6'd63; #1; chk("R10 cr63", cr_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: odd PC then even PC
    cycle(1, 64'hdead_beef_0000_1235, 0, 0, 0, 0, 0, 0);
    cycle(1, 64'h8000_0000_0000_0010, 0, 0, 0, 0, 0, 0);
    cycle(1, 64'hffff_ffff_ffff_ffff, 0, 0, 0, 0, 0, 0);
    // R3: writes elsewhere keep mode
    cycle(0, 0, 1, 6'd7, 64'hffff_ffff_ffff_ffff, 1, 3'd5, 0);
    // R5/R4: upper half of alias write discarded
    cycle(0, 0, 1, 6'd0, 64'habcd_ef01_2345_6789, 0, 0, 0);
    cycle(0, 0, 0, 6'd0, 0, 0, 0, 0);
    chk("R5 cr7 untouched", m_cr[7], 64'hffff_ffff_ffff_ffff);
    cycle(0, 0, 0, 6'd7, 0, 0, 0, 0);
    // R7: each valid code set, unused codes ignored
    cycle(0, 0, 1, 6'd0, 64'd0, 0, 0, 0);
    for (int s = 0; s < 8; s++) cycle(0, 0, 0, 6'd0, 0, 1, 3'(s), 1);
    chk("R7 flag positions", {32'd0, sr}, 64'h0000_7302);
    for (int s = 0; s < 8; s++) cycle(0, 0, 0, 6'd0, 0, 1, 3'(s), 0);
    chk("R7 flags cleared", {32'd0, sr}, 64'd0);
    // R8: single flag preserves others
    cycle(0, 0, 1, 6'd0, 64'hffff_ffff, 0, 0, 0);
    cycle(0, 0, 0, 6'd0, 0, 1, 3'd3, 0);
    chk("R8 one bit cleared", {32'd0, sr}, 64'hffff_fdff);
    // R9: collision
    cycle(0, 0, 1, 6'd0, 64'h0000_0000, 1, 3'd0, 1);
    chk("R9 alias wins", {32'd0, sr}, 64'd0);
    // R6: top entry
    cycle(0, 0, 1, 6'd63, 64'h0123_4567_89ab_cdef, 0, 0, 0);
    cycle(0, 0, 0, 6'd63, 0, 0, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] ci;
      ci = ($urandom % 4 == 0) ? 6'd0 : 6'($urandom % NCR);
      cycle($urandom % 4 == 0, {$urandom, $urandom}, $urandom % 2 == 0, ci,
            {$urandom, $urandom}, $urandom % 3 == 0, 3'($urandom % 8), 1'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule